// File: doc/BRIEF.md
# Secure-Split Bus Error Aggregator

This block gathers error-pending events from up to 64 interconnect segments and records them in two sticky 64-bit pending registers. One register belongs to the Non-Secure world and the other to the Secure world. Each segment has a fixed unique ID, and that ID is the bit position it sets. Segments whose ID is not populated in the build are ignored.

Every error event carries a security tag and a flag that says whether a CPU or a device started the transaction. Only a CPU-started transaction tagged Secure lands in the Secure register. Everything else goes to the Non-Secure register, including device traffic that claims to be Secure. Each register drives its own registered interrupt line, which is the OR of its bits. Both lines also expose their fixed interrupt number on a constant output.

Software reads the registers and clears them through a simple port. The port uses write-1-to-clear with a select bit and an access security tag. The Secure register is shielded from Non-Secure accesses.

Top module: `bus_err_aggregator`

## Requirements
- R1: After synchronous reset both pending registers read zero and both interrupt outputs are low.
- R2: A valid event on a populated segment N tagged Non-Secure sets bit N of the Non-Secure register on the next clock edge, and leaves the Secure register unchanged.
- R3: A valid event tagged Secure that was started by a CPU (cpu flag 1) sets bit N of the Secure register and does not set the Non-Secure bit.
- R4: A valid event started by a device (cpu flag 0) sets the Non-Secure bit, whatever its security tag.
- R5: Events on unpopulated IDs are ignored. The default populated set is IDs 0–6, 8–17, 24–30 and 48, so a pending bit outside that set never reads 1.
- R6: Pending bits are sticky. A register write clears exactly the bits written as 1 (select 0 = Non-Secure register, 1 = Secure register). Bits written as 0 keep their value.
- R7: A clear of the Non-Secure register never changes any Secure bit.
- R8: A write to the Secure register with a Non-Secure access tag (secure input 0) has no effect.
- R9: Reading the Secure register with a Non-Secure access tag returns zero. A Secure-tagged read returns its contents, and a read of the Non-Secure register returns its contents under either tag.
- R10: When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R11: Each interrupt output is registered. It rises one cycle after the first bit of its register becomes set, and it falls one cycle after the register becomes empty.
- R12: The interrupt number outputs carry the parameter values, 32 by default for the Non-Secure line and 33 for the Secure line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| err_valid_i | input | 64 | Per-segment error event strobe, bit = segment ID |
| err_secure_i | input | 64 | Per-segment security tag of the failing transaction |
| err_cpu_i | input | 64 | Per-segment originator flag, 1 = CPU, 0 = device |
| reg_wr_i | input | 1 | Register write strobe (write-1-to-clear) |
| reg_sel_i | input | 1 | Register select, 0 = Non-Secure, 1 = Secure |
| reg_secure_i | input | 1 | Security tag of the register access |
| reg_wdata_i | input | 64 | Clear mask |
| reg_rdata_o | output | 64 | Read data of the selected register (combinational) |
| irq_ns_o | output | 1 | Non-Secure error interrupt |
| irq_sec_o | output | 1 | Secure error interrupt |
| irq_ns_id_o | output | 8 | Interrupt number of the Non-Secure line |
| irq_sec_id_o | output | 8 | Interrupt number of the Secure line |

## Verification
The bench works through routing cases: a device event tagged Secure, events on unpopulated IDs such as 7, 31 and 63, and several segments firing in one cycle. A routing mistake would show the bit in the wrong register or a phantom bit. Privilege cases are checked next. If the guard were missing, a Non-Secure write would wipe Secure bits and a Non-Secure read would leak them. The bench also races an event against a clear of the same bit, which a clear-priority design would lose. Finally it samples the interrupt lines one cycle before and one cycle after the expected change, which catches a combinational or late interrupt.

// File: rtl/bea_pkg.sv
package bea_pkg;

    localparam int unsigned IRQ_ID_W = 8;

    typedef enum logic {
        BANK_NS  = 1'b0,
        BANK_SEC = 1'b1
    } bank_e;

    typedef struct packed {
        logic valid;
        logic secure;
        logic from_cpu;
    } err_evt_t;

    typedef struct packed {
        logic  wr;
        bank_e bank;
        logic  secure;
    } reg_acc_t;

    // Only a CPU-started transaction may claim the Secure bank.
    function automatic bank_e route_bank(input err_evt_t e);
        return (e.secure && e.from_cpu) ? BANK_SEC : BANK_NS;
    endfunction

    function automatic logic acc_may_touch(input reg_acc_t a);
        return (a.bank == BANK_NS) || a.secure;
    endfunction

endpackage

// File: rtl/bea_router.sv
module bea_router
    import bea_pkg::*;
#(
    parameter int unsigned     NSEG      = 64,
    parameter logic [NSEG-1:0] POPULATED = '1
) (
    input  logic [NSEG-1:0] valid_i,
    input  logic [NSEG-1:0] secure_i,
    input  logic [NSEG-1:0] cpu_i,
    output logic [NSEG-1:0] set_ns_o,
    output logic [NSEG-1:0] set_sec_o
);

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        if (POPULATED[g]) begin : g_live
            err_evt_t evt;
            bank_e    dst;
            always_comb begin
                evt.valid    = valid_i[g];
                evt.secure   = secure_i[g];
                evt.from_cpu = cpu_i[g];
                dst          = route_bank(evt);
                set_ns_o[g]  = evt.valid && (dst == BANK_NS);
                set_sec_o[g] = evt.valid && (dst == BANK_SEC);
            end
        end else begin : g_hole
            logic unused_in;
            assign unused_in    = valid_i[g] ^ secure_i[g] ^ cpu_i[g];
            assign set_ns_o[g]  = 1'b0;
            assign set_sec_o[g] = 1'b0;
        end
    end

endmodule

// File: rtl/bea_pend_bank.sv
module bea_pend_bank #(
    parameter int unsigned     NSEG      = 64,
    parameter logic [NSEG-1:0] POPULATED = '1
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NSEG-1:0] set_i,
    input  logic [NSEG-1:0] clr_i,
    output logic [NSEG-1:0] pend_o,
    output logic            irq_o
);

    logic [NSEG-1:0] pend_q;
    logic [NSEG-1:0] pend_d;
    logic            irq_q;

    always_comb begin
        // set is applied after clear, so a same-cycle event wins
        pend_d = ((pend_q & ~clr_i) | set_i) & POPULATED;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            irq_q  <= |pend_q;
        end
    end

    assign pend_o = pend_q;
    assign irq_o  = irq_q;

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> ((pend_q & $past(set_i)) == $past(set_i))); // R10

    AST_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> ((($past(pend_q) & ~pend_q) & ~$past(clr_i)) == '0)); // R6

    AST_HOLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (pend_q & ~POPULATED) == '0); // R5

    AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
        ((pend_q != '0) && !irq_q && !$past(rst_i) && ($past(pend_q) == '0)) |=> irq_q); // R11

endmodule

// File: rtl/bea_regport.sv
module bea_regport
    import bea_pkg::*;
#(
    parameter int unsigned NSEG = 64
) (
    input  logic            wr_i,
    input  logic            sel_i,
    input  logic            secure_i,
    input  logic [NSEG-1:0] wdata_i,
    input  logic [NSEG-1:0] pend_ns_i,
    input  logic [NSEG-1:0] pend_sec_i,
    output logic [NSEG-1:0] clr_ns_o,
    output logic [NSEG-1:0] clr_sec_o,
    output logic [NSEG-1:0] rdata_o
);

    reg_acc_t acc;
    logic     allowed;

    always_comb begin
        acc.wr     = wr_i;
        acc.bank   = bank_e'(sel_i);
        acc.secure = secure_i;
        allowed    = acc_may_touch(acc);

        clr_ns_o  = '0;
        clr_sec_o = '0;
        if (acc.wr && allowed) begin
            if (acc.bank == BANK_SEC) clr_sec_o = wdata_i;
            else                      clr_ns_o  = wdata_i;
        end

        if (!allowed)                  rdata_o = '0;
        else if (acc.bank == BANK_SEC) rdata_o = pend_sec_i;
        else                           rdata_o = pend_ns_i;
    end

    always_comb begin
        AST_NS_READ_MASK: assert (!(sel_i && !secure_i) || (rdata_o == '0)); // R9
    end

endmodule

// File: rtl/bus_err_aggregator.sv
module bus_err_aggregator
    import bea_pkg::*;
#(
    parameter int unsigned     NSEG       = 64,
    parameter logic [NSEG-1:0] POPULATED  = 64'h0001_0000_7F03_FF7F,
    parameter int unsigned     NS_IRQ_ID  = 32,
    parameter int unsigned     SEC_IRQ_ID = 33
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [NSEG-1:0]     err_valid_i,
    input  logic [NSEG-1:0]     err_secure_i,
    input  logic [NSEG-1:0]     err_cpu_i,
    input  logic                reg_wr_i,
    input  logic                reg_sel_i,
    input  logic                reg_secure_i,
    input  logic [NSEG-1:0]     reg_wdata_i,
    output logic [NSEG-1:0]     reg_rdata_o,
    output logic                irq_ns_o,
    output logic                irq_sec_o,
    output logic [IRQ_ID_W-1:0] irq_ns_id_o,
    output logic [IRQ_ID_W-1:0] irq_sec_id_o
);

    localparam int unsigned NBANK = 2;

    logic [NSEG-1:0] set_v  [NBANK];
    logic [NSEG-1:0] clr_v  [NBANK];
    logic [NSEG-1:0] pend_v [NBANK];
    logic            irq_v  [NBANK];

    bea_router #(.NSEG(NSEG), .POPULATED(POPULATED)) u_router (
        .valid_i   (err_valid_i),
        .secure_i  (err_secure_i),
        .cpu_i     (err_cpu_i),
        .set_ns_o  (set_v[BANK_NS]),
        .set_sec_o (set_v[BANK_SEC])
    );

    bea_regport #(.NSEG(NSEG)) u_regport (
        .wr_i       (reg_wr_i),
        .sel_i      (reg_sel_i),
        .secure_i   (reg_secure_i),
        .wdata_i    (reg_wdata_i),
        .pend_ns_i  (pend_v[BANK_NS]),
        .pend_sec_i (pend_v[BANK_SEC]),
        .clr_ns_o   (clr_v[BANK_NS]),
        .clr_sec_o  (clr_v[BANK_SEC]),
        .rdata_o    (reg_rdata_o)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bea_pend_bank #(.NSEG(NSEG), .POPULATED(POPULATED)) u_bank (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .set_i  (set_v[b]),
            .clr_i  (clr_v[b]),
            .pend_o (pend_v[b]),
            .irq_o  (irq_v[b])
        );
    end

    assign irq_ns_o     = irq_v[BANK_NS];
    assign irq_sec_o    = irq_v[BANK_SEC];
    assign irq_ns_id_o  = IRQ_ID_W'(NS_IRQ_ID);
    assign irq_sec_id_o = IRQ_ID_W'(SEC_IRQ_ID);

    AST_DEV_TO_NS: assert property (@(posedge clk_i) disable iff (rst_i)
        !rst_i |=> ((pend_v[BANK_NS] & $past(err_valid_i & ~err_cpu_i & POPULATED))
                    == $past(err_valid_i & ~err_cpu_i & POPULATED))); // R4

    AST_CPU_SEC_ROUTE: assert property (@(posedge clk_i) disable iff (rst_i)
        !rst_i |=> ((pend_v[BANK_SEC] & $past(err_valid_i & err_secure_i & err_cpu_i & POPULATED))
                    == $past(err_valid_i & err_secure_i & err_cpu_i & POPULATED))); // R3

    AST_NS_CLR_SPARES_SEC: assert property (@(posedge clk_i) disable iff (rst_i)
        (reg_wr_i && !reg_sel_i) |=> (($past(pend_v[BANK_SEC]) & ~pend_v[BANK_SEC]) == '0)); // R7

    AST_SEC_WR_GUARD: assert property (@(posedge clk_i) disable iff (rst_i)
        (reg_wr_i && reg_sel_i && !reg_secure_i) |=> (($past(pend_v[BANK_SEC]) & ~pend_v[BANK_SEC]) == '0)); // R8

endmodule

// File: tb/tb_bus_err_aggregator.sv
`timescale 1ns/1ps
module tb_bus_err_aggregator;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] err_valid, err_secure, err_cpu;
    logic        reg_wr, reg_sel, reg_secure;
    logic [63:0] reg_wdata, reg_rdata;
    logic        irq_ns, irq_sec;
    logic [7:0]  irq_ns_id, irq_sec_id;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    bus_err_aggregator dut (
        .clk_i(clk), .rst_i(rst),
        .err_valid_i(err_valid), .err_secure_i(err_secure), .err_cpu_i(err_cpu),
        .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_secure_i(reg_secure),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .irq_ns_o(irq_ns), .irq_sec_o(irq_sec),
        .irq_ns_id_o(irq_ns_id), .irq_sec_id_o(irq_sec_id)
    );

    // id[9:4], secure tag[3], cpu flag[2], expect NS bit[1], expect Secure bit[0]
    localparam logic [9:0] VEC [10] = '{
        {6'd0,  1'b0, 1'b1, 1'b1, 1'b0},
        {6'd6,  1'b1, 1'b1, 1'b0, 1'b1},
        {6'd7,  1'b0, 1'b1, 1'b0, 1'b0},
        {6'd17, 1'b1, 1'b0, 1'b1, 1'b0},
        {6'd24, 1'b0, 1'b0, 1'b1, 1'b0},
        {6'd30, 1'b1, 1'b1, 1'b0, 1'b1},
        {6'd48, 1'b1, 1'b1, 1'b0, 1'b1},
        {6'd63, 1'b0, 1'b1, 1'b0, 1'b0},
        {6'd31, 1'b1, 1'b1, 1'b0, 1'b0},
        {6'd8,  1'b1, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, input logic sec, output logic [63:0] data);
        reg_sel = sel;
        reg_secure = sec;
        #0.5;
        data = reg_rdata;
    endtask

    task automatic wr(input logic sel, input logic sec, input logic [63:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_secure = sec; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [63:0] v, input logic [63:0] s, input logic [63:0] c);
        @(negedge clk);
        err_valid = v; err_secure = s; err_cpu = c;
        @(negedge clk);
        err_valid = '0; err_secure = '0; err_cpu = '0;
    endtask

    task automatic clear_all();
        wr(1'b0, 1'b1, '1);
        wr(1'b1, 1'b1, '1);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        rst = 1'b1; err_valid = '0; err_secure = '0; err_cpu = '0;
        reg_wr = 1'b0; reg_sel = 1'b0; reg_secure = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(1'b0, 1'b1, d); check("R1 ns reg", d, 64'd0);
        rd(1'b1, 1'b1, d); check("R1 sec reg", d, 64'd0);
        check("R1 irqs", {62'd0, irq_ns, irq_sec}, 64'd0);
        // R12 interrupt numbers
        check("R12 ns id", {56'd0, irq_ns_id}, 64'd32);
        check("R12 sec id", {56'd0, irq_sec_id}, 64'd33);

        // table walk: R2 R3 R4 R5 R11
        for (int i = 0; i < 10; i++) begin
            automatic logic [5:0]  id  = VEC[i][9:4];
            automatic logic [63:0] one = 64'd1 << id;
            pulse(one, VEC[i][3] ? one : 64'd0, VEC[i][2] ? one : 64'd0);
            rd(1'b0, 1'b0, d); check("R2/R4/R5 ns route", d, VEC[i][1] ? one : 64'd0);
            rd(1'b1, 1'b1, d); check("R3/R5 sec route", d, VEC[i][0] ? one : 64'd0);
            @(negedge clk);
            check("R11 irq pair", {62'd0, irq_ns, irq_sec}, {62'd0, VEC[i][1], VEC[i][0]});
            clear_all();
        end

        // several segments in one cycle, mixed routes: R2 R3 R4
        pulse(64'h0000_0000_0001_0025, 64'h0000_0000_0001_0004, 64'h0000_0000_0000_0005);
        rd(1'b0, 1'b0, d); check("R4 multi ns", d, 64'h0000_0000_0001_0021);
        rd(1'b1, 1'b1, d); check("R3 multi sec", d, 64'h0000_0000_0000_0004);
        clear_all();

        // R11 timing: irq low the cycle the bit appears, high the next
        pulse(64'd1 << 2, 64'd0, 64'd1 << 2);
        check("R11 irq not yet", {63'd0, irq_ns}, 64'd0);
        @(negedge clk);
        check("R11 irq risen", {63'd0, irq_ns}, 64'd1);

        // R6 sticky and exact clear
        repeat (5) @(negedge clk);
        wr(1'b0, 1'b0, 64'd0);
        wr(1'b0, 1'b0, 64'd1 << 3);
        rd(1'b0, 1'b0, d); check("R6 sticky", d, 64'd1 << 2);
        wr(1'b0, 1'b0, 64'd1 << 2);
        rd(1'b0, 1'b0, d); check("R6 w1c", d, 64'd0);
        check("R11 irq held one cycle", {63'd0, irq_ns}, 64'd1);
        @(negedge clk);
        check("R11 irq fell", {63'd0, irq_ns}, 64'd0);

        // R7 NS clear spares Secure, R8 NS write to Secure ignored, R9 read mask
        pulse(64'd1 << 5, 64'd1 << 5, 64'd1 << 5);
        pulse(64'd1 << 5, 64'd0, 64'd1 << 5);
        wr(1'b0, 1'b0, '1);
        rd(1'b0, 1'b0, d); check("R7 ns cleared", d, 64'd0);
        rd(1'b1, 1'b1, d); check("R7 sec kept", d, 64'd1 << 5);
        wr(1'b1, 1'b0, '1);
        rd(1'b1, 1'b1, d); check("R8 sec write ignored", d, 64'd1 << 5);
        rd(1'b1, 1'b0, d); check("R9 ns read of sec", d, 64'd0);
        wr(1'b1, 1'b1, 64'd1 << 5);
        rd(1'b1, 1'b1, d); check("R8 secure clear works", d, 64'd0);

        // R10 event and clear on the same bit in one cycle
        pulse(64'd1 << 9, 64'd0, 64'd0);
        @(negedge clk);
        err_valid = 64'd1 << 9;
        reg_wr = 1'b1; reg_sel = 1'b0; reg_secure = 1'b0; reg_wdata = 64'd1 << 9;
        @(negedge clk);
        err_valid = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(1'b0, 1'b0, d); check("R10 set wins", d, 64'd1 << 9);
        wr(1'b0, 1'b0, 64'd1 << 9);
        rd(1'b0, 1'b0, d); check("R10 later clear", d, 64'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule